// File: doc/BRIEF.md
# I2C Master Bit-Timing Generator

This block turns single-cycle command strobes into correctly timed open-drain drive for the two I2C lines. It runs on a fast kernel clock and covers four bus actions: START, one data bit, repeated START and STOP. All line timing is derived from one packed timing word. That word holds a prescaler, a hold delay, a setup delay, a high count and a low count. Every phase length is a whole number of prescaled ticks.

The SCL input is passed through a synchronizer and an optional glitch filter. The high phase and the repeated-START and STOP setup phases start counting only once the filtered line is seen high. A device that stretches the clock by holding SCL low therefore lengthens the bit without extra logic. Once SCL has been pulled low, the master holds it low until the next command arrives. During the low phase, SDA changes only after the hold delay. SCL is released only after both the setup delay and the programmed low count have run out.

A byte-level controller drives the command strobes and waits for `bit_done` before it issues the next command. The timing word and filter length are taken only while the block is idle.

Top module: `i2c_bit_timer`

## Requirements
- R1: While reset is asserted and right after it is released, `scl_oe`, `sda_oe` and `bit_done` are all 0. An `_oe` output at 1 pulls its line low.
- R2: In idle, `cmd_start` sets `sda_oe` to 1 at the edge that accepts it. `scl_oe` then goes to 1 exactly (high+1)·(P+1) kernel cycles later.
- R3: A data-bit command accepted at edge E sets `sda_oe` to the inverse of `bit_val`, hold·(P+1) cycles after E. A hold value of 0 makes the change at E itself. SCL is driven low whenever SDA changes in this phase.
- R4: After a bit, repeated-START or STOP command accepted at edge E, `scl_oe` returns to 0 at E + max(low+1, hold+setup+1)·(P+1).
- R5: With no stretching, `scl_oe` stays 0 for 3 + DNF + (high+1)·(P+1) cycles during a data bit. This assumes the default two-stage synchronizer. `sda_oe` does not change during the counted high phase.
- R6: If the SCL line stays low after release, the high count waits. Counting starts 3 + DNF cycles after the line actually rises. While waiting for a command after a bit, `scl_oe` stays 1.
- R7: With filter length DNF > 0, a high pulse on SCL shorter than DNF kernel cycles is not accepted as a rising edge. With DNF = 0 the filter is bypassed.
- R8: Repeated START: after the line is seen high, SCL stays released for (low+1)·(P+1) cycles, then `sda_oe` goes to 1. After a further (high+1)·(P+1) cycles, `scl_oe` goes to 1.
- R9: STOP: SDA is driven low in the low phase. After SCL is seen high, (high+1)·(P+1) cycles pass before `sda_oe` goes to 0. After a further (low+1)·(P+1) cycles of bus-free time, `bit_done` pulses and both outputs stay 0.
- R10: `bit_done` is a one-cycle pulse. For START, bit and repeated START, it comes 3 + DNF cycles after `scl_oe` rises.
- R11: The fields of `timing_word` are prescale P [3:0], hold [7:4], setup [11:8], high [19:12] and low [27:20]. The word and `filt_len` are taken only while idle. Changes made during a transfer have no effect on its timing.
- R12: Strobes that do not apply to the current phase are ignored. Examples are a bit, repeated-START or STOP strobe in idle, or a START strobe while SCL is held low. Such strobes leave the lines and `bit_done` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timing_word | input | 28 | Packed prescale, hold, setup, high and low counts |
| filt_len | input | 4 | Glitch filter length in kernel cycles, 0 bypasses |
| scl_in | input | 1 | Sampled SCL bus line |
| cmd_start | input | 1 | Request START from idle |
| cmd_bit | input | 1 | Request one data bit |
| cmd_rstart | input | 1 | Request repeated START |
| cmd_stop | input | 1 | Request STOP |
| bit_val | input | 1 | Data bit for `cmd_bit` (1 = released) |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| bit_done | output | 1 | One-cycle completion pulse |

## Verification
Each line edge and each `bit_done` pulse is predicted to the exact kernel cycle from the programmed fields. A wrong counter load, a lost tick or a mis-ordered phase therefore shows up as an edge one or more ticks early or late, at the first bus event after the fault. A broken synchronizer or filter path shifts every high phase by whole cycles, or lets a short glitch start the high count early. That error appears at the next SCL low edge. Stale configuration or an accepted illegal strobe produces an unexpected edge within the window the bench watches.

// File: rtl/i2c_bt_pkg.sv
package i2c_bt_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_STHOLD,
      S_FALL,
      S_HELD,
      S_LOWP,
      S_RISE,
      S_HIGHP,
      S_RSSET,
      S_SPSET,
      S_BFREE
   } bt_state_e;

   typedef enum logic [1:0] {
      OP_BIT,
      OP_RSTART,
      OP_STOP
   } bt_op_e;

endpackage

// File: rtl/i2c_bt_tick.sv
// Prescaled time base: one tick every (div+1) kernel cycles, realigned
// by restart so that each counted phase begins on a fresh tick window.
module i2c_bt_tick #(
   parameter int PW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   input  logic [PW-1:0] div,
   output logic          tick
);

   logic [PW-1:0] pc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc <= '0;
      end else if (restart || pc == div) begin
         pc <= '0;
      end else begin
         pc <= pc + 1'b1;
      end
   end

   assign tick = (pc == div);

endmodule

// File: rtl/i2c_bt_sync_filt.sv
// Line synchronizer followed by an optional stability filter.
module i2c_bt_sync_filt #(
   parameter int STAGES  = 2,
   parameter int DW      = 4,
   parameter bit FILT_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          din,
   input  logic [DW-1:0] len,
   output logic          dout
);

   logic [STAGES-1:0] sr;
   logic              s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr <= '1;
      end else begin
         sr <= {sr[STAGES-2:0], din};
      end
   end

   assign s = sr[STAGES-1];

   generate
      if (FILT_EN) begin : g_filter
         logic          fo;
         logic [DW-1:0] fc;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               fo <= 1'b1;
               fc <= '0;
            end else if (len == '0) begin
               fo <= s;
               fc <= '0;
            end else if (s != fo) begin
               if (fc == len - 1'b1) begin
                  fo <= s;
                  fc <= '0;
               end else begin
                  fc <= fc + 1'b1;
               end
            end else begin
               fc <= '0;
            end
         end

         assign dout = (len == '0) ? s : fo;
      end else begin : g_bypass
         assign dout = s;
      end
   endgenerate

endmodule

// File: rtl/i2c_bt_engine.sv
// Phase sequencer: walks START, data bit, repeated START and STOP through
// counted and edge-waiting phases and drives the open-drain enables.
module i2c_bt_engine
   import i2c_bt_pkg::*;
#(
   parameter int DW = 4,
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          scl_f,
   input  logic          cmd_start,
   input  logic          cmd_bit,
   input  logic          cmd_rstart,
   input  logic          cmd_stop,
   input  logic          bit_val,
   input  logic [DW-1:0] f_hold,
   input  logic [DW-1:0] f_setup,
   input  logic [CW-1:0] f_high,
   input  logic [CW-1:0] f_low,
   output logic          restart,
   output logic          scl_oe,
   output logic          sda_oe,
   output logic          bit_done,
   output bt_state_e     st
);

   bt_op_e        op;
   logic [CW-1:0] tc_a;
   logic [DW-1:0] tc_b;
   logic          la_done, lb_done, in_setup, dat;
   logic          la_fin, lb_fin, any_cmd, a_zero;

   assign any_cmd = cmd_bit | cmd_rstart | cmd_stop;
   assign a_zero  = (tc_a == '0);
   assign la_fin  = la_done | a_zero;
   assign lb_fin  = lb_done | (in_setup && tc_b == '0);

   always_comb begin
      restart = 1'b0;
      case (st)
         S_IDLE:          restart = cmd_start;
         S_HELD:          restart = any_cmd;
         S_RISE:          restart = scl_f;
         S_RSSET, S_SPSET: restart = tick && a_zero;
         default:         restart = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         op       <= OP_BIT;
         tc_a     <= '0;
         tc_b     <= '0;
         la_done  <= 1'b0;
         lb_done  <= 1'b0;
         in_setup <= 1'b0;
         dat      <= 1'b1;
         scl_oe   <= 1'b0;
         sda_oe   <= 1'b0;
         bit_done <= 1'b0;
      end else begin
         bit_done <= 1'b0;
         case (st)
            S_IDLE: begin
               scl_oe <= 1'b0;
               sda_oe <= 1'b0;
               if (cmd_start) begin
                  sda_oe <= 1'b1;
                  tc_a   <= f_high;
                  st     <= S_STHOLD;
               end
            end
            S_STHOLD: begin
               if (tick) begin
                  if (a_zero) begin
                     scl_oe <= 1'b1;
                     st     <= S_FALL;
                  end else begin
                     tc_a <= tc_a - 1'b1;
                  end
               end
            end
            S_FALL: begin
               if (!scl_f) begin
                  st       <= S_HELD;
                  bit_done <= 1'b1;
               end
            end
            S_HELD: begin
               if (any_cmd) begin
                  if (cmd_bit) begin
                     op  <= OP_BIT;
                     dat <= bit_val;
                  end else if (cmd_rstart) begin
                     op  <= OP_RSTART;
                     dat <= 1'b1;
                  end else begin
                     op  <= OP_STOP;
                     dat <= 1'b0;
                  end
                  tc_a    <= f_low;
                  la_done <= 1'b0;
                  lb_done <= 1'b0;
                  if (f_hold == '0) begin
                     in_setup <= 1'b1;
                     tc_b     <= f_setup;
                     if (cmd_bit)         sda_oe <= !bit_val;
                     else if (cmd_rstart) sda_oe <= 1'b0;
                     else                 sda_oe <= 1'b1;
                  end else begin
                     in_setup <= 1'b0;
                     tc_b     <= f_hold - 1'b1;
                  end
                  st <= S_LOWP;
               end
            end
            S_LOWP: begin
               if (tick) begin
                  la_done <= la_fin;
                  lb_done <= lb_fin;
                  if (!la_done && !a_zero) begin
                     tc_a <= tc_a - 1'b1;
                  end
                  if (!lb_done) begin
                     if (!in_setup) begin
                        if (tc_b == '0) begin
                           in_setup <= 1'b1;
                           tc_b     <= f_setup;
                           sda_oe   <= !dat;
                        end else begin
                           tc_b <= tc_b - 1'b1;
                        end
                     end else if (tc_b != '0) begin
                        tc_b <= tc_b - 1'b1;
                     end
                  end
                  if (la_fin && lb_fin) begin
                     scl_oe <= 1'b0;
                     st     <= S_RISE;
                  end
               end
            end
            S_RISE: begin
               if (scl_f) begin
                  case (op)
                     OP_BIT: begin
                        tc_a <= f_high;
                        st   <= S_HIGHP;
                     end
                     OP_RSTART: begin
                        tc_a <= f_low;
                        st   <= S_RSSET;
                     end
                     default: begin
                        tc_a <= f_high;
                        st   <= S_SPSET;
                     end
                  endcase
               end
            end
            S_HIGHP: begin
               if (tick) begin
                  if (a_zero) begin
                     scl_oe <= 1'b1;
                     st     <= S_FALL;
                  end else begin
                     tc_a <= tc_a - 1'b1;
                  end
               end
            end
            S_RSSET: begin
               if (tick) begin
                  if (a_zero) begin
                     sda_oe <= 1'b1;
                     tc_a   <= f_high;
                     st     <= S_STHOLD;
                  end else begin
                     tc_a <= tc_a - 1'b1;
                  end
               end
            end
            S_SPSET: begin
               if (tick) begin
                  if (a_zero) begin
                     sda_oe <= 1'b0;
                     tc_a   <= f_low;
                     st     <= S_BFREE;
                  end else begin
                     tc_a <= tc_a - 1'b1;
                  end
               end
            end
            S_BFREE: begin
               if (tick) begin
                  if (a_zero) begin
                     st       <= S_IDLE;
                     bit_done <= 1'b1;
                  end else begin
                     tc_a <= tc_a - 1'b1;
                  end
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/i2c_bit_timer.sv
module i2c_bit_timer
   import i2c_bt_pkg::*;
#(
   parameter int PRE_W       = 4,
   parameter int DLY_W       = 4,
   parameter int CNT_W       = 8,
   parameter int DNF_W       = 4,
   parameter int SYNC_STAGES = 2,
   parameter bit FILT_EN     = 1'b1,
   localparam int OFF_HOLD   = PRE_W,
   localparam int OFF_SET    = OFF_HOLD + DLY_W,
   localparam int OFF_HIGH   = OFF_SET + DLY_W,
   localparam int OFF_LOW    = OFF_HIGH + CNT_W,
   localparam int TW_W       = OFF_LOW + CNT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TW_W-1:0]  timing_word,
   input  logic [DNF_W-1:0] filt_len,
   input  logic             scl_in,
   input  logic             cmd_start,
   input  logic             cmd_bit,
   input  logic             cmd_rstart,
   input  logic             cmd_stop,
   input  logic             bit_val,
   output logic             scl_oe,
   output logic             sda_oe,
   output logic             bit_done
);

   generate
      if (SYNC_STAGES < 2) begin : g_chk_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (PRE_W < 1 || DLY_W < 1 || CNT_W < 1 || DNF_W < 1) begin : g_chk_w
         $error("field widths must be positive");
      end
   endgenerate

   bt_state_e        st_w;
   logic [TW_W-1:0]  cfg_q, cfg_nx;
   logic [DNF_W-1:0] dnf_q;
   logic             idle, tick, restart, scl_f;

   assign idle   = (st_w == S_IDLE);
   assign cfg_nx = idle ? timing_word : cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
         dnf_q <= '0;
      end else begin
         cfg_q <= cfg_nx;
         if (idle) dnf_q <= filt_len;
      end
   end

   i2c_bt_tick #(.PW(PRE_W)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .div     (cfg_nx[PRE_W-1:0]),
      .tick    (tick)
   );

   i2c_bt_sync_filt #(
      .STAGES  (SYNC_STAGES),
      .DW      (DNF_W),
      .FILT_EN (FILT_EN)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (scl_in),
      .len   (dnf_q),
      .dout  (scl_f)
   );

   i2c_bt_engine #(.DW(DLY_W), .CW(CNT_W)) u_eng (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .scl_f      (scl_f),
      .cmd_start  (cmd_start),
      .cmd_bit    (cmd_bit),
      .cmd_rstart (cmd_rstart),
      .cmd_stop   (cmd_stop),
      .bit_val    (bit_val),
      .f_hold     (cfg_nx[OFF_HOLD +: DLY_W]),
      .f_setup    (cfg_nx[OFF_SET  +: DLY_W]),
      .f_high     (cfg_nx[OFF_HIGH +: CNT_W]),
      .f_low      (cfg_nx[OFF_LOW  +: CNT_W]),
      .restart    (restart),
      .scl_oe     (scl_oe),
      .sda_oe     (sda_oe),
      .bit_done   (bit_done),
      .st         (st_w)
   );

endmodule

// File: rtl/i2c_bit_timer_chk.sv
module i2c_bit_timer_chk
   import i2c_bt_pkg::*;
#(
   parameter int TW_W = 28
) (
   input logic            clk,
   input logic            rst_n,
   input logic            scl_oe,
   input logic            sda_oe,
   input logic            bit_done,
   input bt_state_e       st,
   input logic [TW_W-1:0] cfg
);

   p_reset_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!scl_oe && !sda_oe && !bit_done));

   p_sda_moves_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_LOWP && !$stable(sda_oe)) |-> scl_oe);

   p_sda_steady_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_HIGHP && $past(st) == S_HIGHP) |-> $stable(sda_oe));

   p_held_scl_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_HELD) |-> scl_oe);

   p_idle_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_IDLE && $past(st) == S_IDLE) |-> (!scl_oe && !sda_oe));

   p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      bit_done |=> !bit_done);

   p_cfg_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (st != S_IDLE && $past(st) != S_IDLE) |-> $stable(cfg));

endmodule

bind i2c_bit_timer i2c_bit_timer_chk #(.TW_W(TW_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .scl_oe   (scl_oe),
   .sda_oe   (sda_oe),
   .bit_done (bit_done),
   .st       (st_w),
   .cfg      (cfg_q)
);

// File: tb/sim_i2c_bit_timer.sv
`timescale 1ns/1ps
module sim_i2c_bit_timer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [27:0] timing_word = '0;
   logic [3:0]  filt_len = '0;
   logic        cmd_start = 1'b0, cmd_bit = 1'b0, cmd_rstart = 1'b0, cmd_stop = 1'b0;
   logic        bit_val = 1'b0;
   logic        slv_hold = 1'b0;
   logic        scl_oe, sda_oe, bit_done;
   logic        scl_line;

   assign scl_line = !(scl_oe | slv_hold);

   always #5 clk = !clk;

   i2c_bit_timer u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .timing_word (timing_word),
      .filt_len    (filt_len),
      .scl_in      (scl_line),
      .cmd_start   (cmd_start),
      .cmd_bit     (cmd_bit),
      .cmd_rstart  (cmd_rstart),
      .cmd_stop    (cmd_stop),
      .bit_val     (bit_val),
      .scl_oe      (scl_oe),
      .sda_oe      (sda_oe),
      .bit_done    (bit_done)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int nchk = 0, nerr = 0;
   bit finished = 1'b0;

   // event kinds: 0 scl pulled low, 1 scl released, 2 sda pulled low,
   // 3 sda released, 4 bit_done pulse
   int    q_kind[$];
   int    q_cyc[$];
   string q_tag[$];

   int m_p, m_h, m_s, m_hi, m_lo, m_d, m_t;
   bit cur_sda;

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic push(input int k, input int c, input string tag);
      q_kind.push_back(k);
      q_cyc.push_back(c);
      q_tag.push_back(tag);
   endtask

   task automatic ev(input int k);
      int ek, ec;
      string et;
      if (q_kind.size() == 0) begin
         chk(1'b0, "R12", $sformatf("unexpected event kind %0d at cycle", k), cyc, -1);
      end else begin
         ek = q_kind.pop_front();
         ec = q_cyc.pop_front();
         et = q_tag.pop_front();
         chk(ek == k && ec == cyc, et,
             $sformatf("event kind %0d (expected kind %0d) cycle", k, ek), cyc, ec);
      end
   endtask

   // monitor: detects output edges between clock edges and scores them
   logic p_scl = 1'b0, p_sda = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (scl_oe !== p_scl) ev(scl_oe ? 0 : 1);
         if (sda_oe !== p_sda) ev(sda_oe ? 2 : 3);
         if (bit_done) ev(4);
      end
      p_scl = scl_oe;
      p_sda = sda_oe;
   end

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   task automatic set_cfg(input int p, input int h, input int s, input int hi,
                          input int lo, input int d);
      m_p = p; m_h = h; m_s = s; m_hi = hi; m_lo = lo; m_d = d; m_t = p + 1;
      timing_word = {lo[7:0], hi[7:0], s[3:0], h[3:0], p[3:0]};
      filt_len = d[3:0];
      repeat (4) @(negedge clk);
   endtask

   task automatic wait_done();
      do @(negedge clk); while (!bit_done);
   endtask

   task automatic do_start();
      int e, f;
      @(negedge clk);
      cmd_start = 1'b1;
      e = cyc + 1;
      push(2, e, "R2");
      f = e + (m_hi + 1) * m_t;
      push(0, f, "R2");
      push(4, f + 3 + m_d, "R10");
      cur_sda = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0;
      wait_done();
   endtask

   // low phase shared by bit, repeated START and STOP; returns release edge
   task automatic low_phase(input int e, input bit tgt, input string tag,
                            output int r);
      if (tgt != cur_sda) push(tgt ? 2 : 3, e + m_h * m_t, tag);
      cur_sda = tgt;
      r = e + imax(m_lo + 1, m_h + m_s + 1) * m_t;
      push(1, r, "R4");
   endtask

   task automatic do_bit(input bit b, input int q, input int gl_at,
                         input int gl_len, input bit scramble);
      int e, r, x, f;
      logic [27:0] keep;
      @(negedge clk);
      if (q > 0) slv_hold = 1'b1;
      cmd_bit = 1'b1;
      bit_val = b;
      e = cyc + 1;
      low_phase(e, !b, "R3", r);
      x = r + q;
      f = x + 3 + m_d + (m_hi + 1) * m_t;
      push(0, f, (q > 0) ? ((gl_len > 0) ? "R7" : "R6") : "R5");
      push(4, f + 3 + m_d, "R10");
      keep = timing_word;
      @(negedge clk);
      cmd_bit = 1'b0;
      if (scramble) timing_word = ~timing_word; // R11: ignored mid-transfer
      while (q > 0 && cyc < r + q) begin
         @(negedge clk);
         if (gl_len > 0 && cyc == r + gl_at) slv_hold = 1'b0;
         if (gl_len > 0 && cyc == r + gl_at + gl_len) slv_hold = 1'b1;
      end
      slv_hold = 1'b0;
      wait_done();
      timing_word = keep;
   endtask

   task automatic do_rstart();
      int e, r, s, f;
      @(negedge clk);
      cmd_rstart = 1'b1;
      e = cyc + 1;
      low_phase(e, 1'b0, "R8", r);
      s = r + 3 + m_d + (m_lo + 1) * m_t;
      push(2, s, "R8");
      f = s + (m_hi + 1) * m_t;
      push(0, f, "R8");
      push(4, f + 3 + m_d, "R10");
      cur_sda = 1'b1;
      @(negedge clk);
      cmd_rstart = 1'b0;
      wait_done();
   endtask

   task automatic do_stop();
      int e, r, p;
      @(negedge clk);
      cmd_stop = 1'b1;
      e = cyc + 1;
      low_phase(e, 1'b1, "R9", r);
      p = r + 3 + m_d + (m_hi + 1) * m_t;
      push(3, p, "R9");
      push(4, p + (m_lo + 1) * m_t, "R9");
      cur_sda = 1'b0;
      @(negedge clk);
      cmd_stop = 1'b0;
      wait_done();
   endtask

   task automatic pulse(input int which);
      @(negedge clk);
      case (which)
         0: cmd_start = 1'b1;
         1: cmd_bit = 1'b1;
         2: cmd_rstart = 1'b1;
         default: cmd_stop = 1'b1;
      endcase
      @(negedge clk);
      cmd_start = 1'b0; cmd_bit = 1'b0; cmd_rstart = 1'b0; cmd_stop = 1'b0;
   endtask

   initial begin
      cur_sda = 1'b0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(scl_oe == 1'b0 && sda_oe == 1'b0 && bit_done == 1'b0, "R1",
          "outputs during reset", {scl_oe, sda_oe, bit_done}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(scl_oe == 1'b0 && sda_oe == 1'b0 && bit_done == 1'b0, "R1",
          "outputs after reset", {scl_oe, sda_oe, bit_done}, 0);

      // config A: low count dominates, hold > 0, no filter
      set_cfg(1, 2, 1, 4, 5, 0);
      do_start();
      do_bit(1'b1, 0, 0, 0, 1'b0);
      do_bit(1'b0, 0, 0, 0, 1'b0);
      do_bit(1'b0, 0, 0, 0, 1'b0);
      do_bit(1'b1, 20, 0, 0, 1'b0);   // R6 clock stretching
      do_rstart();                    // R8
      do_bit(1'b0, 0, 0, 0, 1'b0);
      do_stop();                      // R9

      // R12: wrong-phase strobes in idle have no effect
      pulse(1); pulse(2); pulse(3);
      repeat (40) @(negedge clk);
      chk(scl_oe == 1'b0 && sda_oe == 1'b0 && q_kind.size() == 0, "R12",
          "lines after idle strobes", {scl_oe, sda_oe}, 0);

      // config B (R11: new word taken in idle): setup dominates, hold 0, filter 3
      set_cfg(0, 0, 7, 2, 3, 3);
      do_start();
      // R12: START while SCL is held low is ignored
      pulse(0);
      repeat (40) @(negedge clk);
      chk(scl_oe == 1'b1 && q_kind.size() == 0, "R12",
          "scl held after stray start", scl_oe, 1);
      do_bit(1'b1, 0, 0, 0, 1'b0);    // R3 zero hold
      do_bit(1'b0, 30, 5, 2, 1'b0);   // R7 glitch shorter than filter
      do_bit(1'b1, 0, 0, 0, 1'b1);    // R11 word changed mid-bit
      do_stop();

      // config C: prescale 3, zero high/low counts, filter 1
      set_cfg(3, 1, 0, 0, 0, 1);
      do_start();
      do_bit(1'b0, 0, 0, 0, 1'b0);
      do_bit(1'b1, 0, 0, 0, 1'b0);
      do_rstart();
      do_stop();

      repeat (30) @(negedge clk);
      chk(q_kind.size() == 0, "R9", "expected events never seen", q_kind.size(), 0);
      chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R9", "bus released at end",
          {scl_oe, sda_oe}, 0);

      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         nchk++;
         nerr++;
         $display("FAIL watchdog run did not complete actual=%0d expected=0", cyc);
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

endmodule